// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block is the command front end and write controller of a small byte-wide flash array. A bus front end delivers decoded write cycles (address, data and a one-cycle strobe). The sequencer recognises multi-cycle unlock sequences that start a byte program, a whole-array erase, a permanent lockout of the boot region, or entry into and exit from an identification mode. Accepted operations run under an internal cycle timer and update a behavioural array held in inferable dual-port memory.

Reads use a separate port with one cycle of latency. While an operation runs, a read returns a polling status byte instead of array contents. In identification mode, a read returns fixed identity codes and the lockout state. The shipping configuration is `ADDR_W=16` with `BOOT_W=13`, which gives 64K bytes and an 8K boot region. The defaults are scaled down to `ADDR_W=12` and `BOOT_W=9` so that simulation stays small. Command addresses are compared on the low `ADDR_W` bits.

Top module: `flash_cmd_seq`

## Requirements
- R1: At power-up every byte reads FFh. After reset, `busy` is 0 and `op_kind` is 00.
- R2: The writes 555h/AAh, AAAh/55h and 555h/A0h, followed by any address/data write, program that byte. The stored value becomes old AND new. `busy` stays high for exactly `PROG_CYCLES` cycles, with `op_kind` = 01.
- R3: The writes 555h/AAh, AAAh/55h, 555h/80h, 555h/AAh, AAAh/55h and 555h/10h erase the array. Every unprotected byte becomes FFh. `busy` stays high for exactly `ERASE_CYCLES` cycles, with `op_kind` = 10.
- R4: The same six-write sequence ending in 555h/40h sets `boot_locked`. After that, a program aimed below address 2^`BOOT_W` is dropped: `busy` stays low and the byte is unchanged. An erase also leaves that region intact. Addresses from 2^`BOOT_W` upward stay programmable and erasable.
- R5: Once set, `boot_locked` is never cleared, neither by any command nor by `rst`.
- R6: The writes 555h/AAh, AAAh/55h and 555h/90h enter identification mode. In that mode, a read of address 0 returns `MFR_CODE` and a read of address 1 returns `DEV_CODE`. A read of address 2 returns `boot_locked` in bit 0 with the other bits zero. Any other address reads 00h. The sequence ending in 555h/F0h restores normal array reads.
- R7: A write that does not match the expected step of a sequence returns the sequencer to idle. The array is not changed and no operation starts.
- R8: While `busy` is high, a read returns a status byte. Bit 7 is the complement of bit 7 of the byte being programmed, or 0 during an erase. Bit 6 changes value on each successive read. Bits 5..0 are 0.
- R9: Writes that arrive while `busy` is high are ignored and do not advance any sequence.
- R10: `rd_data` presents the result of a read in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not clear lockout) |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result, one cycle after `rd_en` |
| busy | output | 1 | Program or erase in progress |
| op_kind | output | 2 | 00 idle, 01 program, 10 erase |
| boot_locked | output | 1 | Boot region lockout is active |

## Verification
The hardest situation to reach is an erase that runs after lockout. It must be shown to sweep the main region back to FFh while boot bytes written earlier survive. The stimulus writes known patterns on both sides of the boundary and then issues the lock sequence. It checks the lock through identification mode, issues a full erase, and reads the bytes at 2^`BOOT_W`-1 and 2^`BOOT_W` as well as the earlier patterns. Ignoring writes while busy is shown by sending a complete program sequence inside another program's busy window, then confirming that the targeted byte is still FFh once both windows have elapsed.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PDATA,
    SQ_EUNL0,
    SQ_EUNL1,
    SQ_EFIN
  } seq_st_e;

  typedef enum logic [1:0] {
    RS_ARRAY,
    RS_ID,
    RS_STAT
  } rd_src_e;

  typedef struct packed {
    logic prog;
    logic erase;
    logic lock;
    logic id_in;
    logic id_out;
  } cmd_t;

  localparam logic [15:0] CMD_ADDR_1 = 16'h5555;
  localparam logic [15:0] CMD_ADDR_2 = 16'h2AAA;

  localparam logic [7:0] CD_KEY_A  = 8'hAA;
  localparam logic [7:0] CD_KEY_B  = 8'h55;
  localparam logic [7:0] CD_PROG   = 8'hA0;
  localparam logic [7:0] CD_ERPRE  = 8'h80;
  localparam logic [7:0] CD_ID_IN  = 8'h90;
  localparam logic [7:0] CD_ID_OUT = 8'hF0;
  localparam logic [7:0] CD_ERASE  = 8'h10;
  localparam logic [7:0] CD_LOCK   = 8'h40;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output cmd_t              cmd
);

  localparam logic [ADDR_W-1:0] KEY_ADDR_1 = CMD_ADDR_1[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] KEY_ADDR_2 = CMD_ADDR_2[ADDR_W-1:0];

  seq_st_e st_q, st_nx;
  logic    take;
  logic    at_a1, at_a2;

  assign take  = wr_en && !busy;
  assign at_a1 = (wr_addr == KEY_ADDR_1);
  assign at_a2 = (wr_addr == KEY_ADDR_2);

  always_comb begin
    st_nx = st_q;
    cmd   = '0;
    if (take) begin
      unique case (st_q)
        SQ_IDLE:  st_nx = (at_a1 && wr_data == CD_KEY_A) ? SQ_UNL1 : SQ_IDLE;
        SQ_UNL1:  st_nx = (at_a2 && wr_data == CD_KEY_B) ? SQ_UNL2 : SQ_IDLE;
        SQ_UNL2: begin
          st_nx = SQ_IDLE;
          if (at_a1) begin
            unique case (wr_data)
              CD_PROG:   st_nx = SQ_PDATA;
              CD_ERPRE:  st_nx = SQ_EUNL0;
              CD_ID_IN:  cmd.id_in = 1'b1;
              CD_ID_OUT: cmd.id_out = 1'b1;
              default:   st_nx = SQ_IDLE;
            endcase
          end
        end
        SQ_PDATA: begin
          cmd.prog = 1'b1;
          st_nx    = SQ_IDLE;
        end
        SQ_EUNL0: st_nx = (at_a1 && wr_data == CD_KEY_A) ? SQ_EUNL1 : SQ_IDLE;
        SQ_EUNL1: st_nx = (at_a2 && wr_data == CD_KEY_B) ? SQ_EFIN : SQ_IDLE;
        SQ_EFIN: begin
          st_nx = SQ_IDLE;
          if (at_a1 && wr_data == CD_ERASE) cmd.erase = 1'b1;
          if (at_a1 && wr_data == CD_LOCK)  cmd.lock  = 1'b1;
        end
        default:  st_nx = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SQ_IDLE;
    else     st_q <= st_nx;
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(st_q)); // R9

  AST_CMD_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd)); // R7

endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int BOOT_W       = 9,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 4104
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_prog,
  input  logic              go_erase,
  input  logic              go_lock,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              busy,
  output op_kind_e          op_kind,
  output logic              locked,
  output logic              poll7,
  output logic [ADDR_W-1:0] a_addr,
  output logic              a_we,
  output logic [7:0]        a_wdata,
  input  logic [7:0]        a_rdata
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  if (ERASE_CYCLES <= DEPTH || PROG_CYCLES < 2 || BOOT_W >= ADDR_W) begin : g_bad_param
    $error("flash_cmd_engine: ERASE_CYCLES must exceed depth, PROG_CYCLES >= 2, BOOT_W < ADDR_W");
  end

  function automatic logic in_boot(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BOOT_W] == '0;
  endfunction

  op_kind_e          op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [7:0]        dat_q;
  logic [ADDR_W:0]   sweep_q;
  logic              lock_q = 1'b0;
  logic              sweep_live;
  logic              prog_ok;

  assign sweep_live = (op_q == OP_ERASE) && !sweep_q[ADDR_W];
  assign prog_ok    = go_prog && !(lock_q && in_boot(cmd_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_NONE;
      cnt_q   <= '0;
      tgt_q   <= '0;
      dat_q   <= '0;
      sweep_q <= '0;
    end else begin
      unique case (op_q)
        OP_NONE: begin
          if (prog_ok) begin
            op_q  <= OP_PROG;
            cnt_q <= CNT_W'(PROG_CYCLES - 1);
            tgt_q <= cmd_addr;
            dat_q <= cmd_data;
          end else if (go_erase) begin
            op_q    <= OP_ERASE;
            cnt_q   <= CNT_W'(ERASE_CYCLES - 1);
            sweep_q <= '0;
          end
        end
        OP_PROG: begin
          if (cnt_q == '0) op_q <= OP_NONE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        OP_ERASE: begin
          if (cnt_q == '0) op_q <= OP_NONE;
          else             cnt_q <= cnt_q - 1'b1;
          if (!sweep_q[ADDR_W]) sweep_q <= sweep_q + 1'b1;
        end
        default: op_q <= OP_NONE;
      endcase
    end
  end

  // Lockout is non-volatile: reset does not touch it.
  always_ff @(posedge clk) begin
    if (go_lock) lock_q <= 1'b1;
  end

  always_comb begin
    a_addr  = (op_q == OP_ERASE) ? sweep_q[ADDR_W-1:0] : tgt_q;
    a_we    = ((op_q == OP_PROG) && (cnt_q == '0)) ||
              (sweep_live && !(lock_q && in_boot(sweep_q[ADDR_W-1:0])));
    a_wdata = (op_q == OP_PROG) ? (a_rdata & dat_q) : 8'hFF;
  end

  assign busy    = (op_q != OP_NONE);
  assign op_kind = op_q;
  assign locked  = lock_q;
  assign poll7   = (op_q == OP_PROG) ? ~dat_q[7] : 1'b0;

  AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (rst)
    (a_we && lock_q) |-> (a_addr[ADDR_W-1:BOOT_W] != '0)); // R4

  AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q); // R5

  AST_PROG_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_PROG) |-> (cnt_q < CNT_W'(PROG_CYCLES))); // R2

  AST_SWEEP_DONE: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_ERASE && cnt_q == '0) |-> sweep_q[ADDR_W]); // R3

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    a_we |-> busy); // R9

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W       = 12,
  parameter int          BOOT_W       = 9,
  parameter int          PROG_CYCLES  = 20,
  parameter int          ERASE_CYCLES = 4104,
  parameter logic [7:0]  MFR_CODE     = 8'h3C,
  parameter logic [7:0]  DEV_CODE     = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic [1:0]        op_kind,
  output logic              boot_locked
);

  cmd_t              cmd;
  op_kind_e          op_e;
  logic              poll7;
  logic [ADDR_W-1:0] a_addr;
  logic              a_we;
  logic [7:0]        a_wdata, a_rdata, b_rdata;

  flash_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .cmd     (cmd)
  );

  flash_cmd_engine #(
    .ADDR_W       (ADDR_W),
    .BOOT_W       (BOOT_W),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .go_prog  (cmd.prog),
    .go_erase (cmd.erase),
    .go_lock  (cmd.lock),
    .cmd_addr (wr_addr),
    .cmd_data (wr_data),
    .busy     (busy),
    .op_kind  (op_e),
    .locked   (boot_locked),
    .poll7    (poll7),
    .a_addr   (a_addr),
    .a_we     (a_we),
    .a_wdata  (a_wdata),
    .a_rdata  (a_rdata)
  );

  flash_cmd_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk     (clk),
    .a_addr  (a_addr),
    .a_we    (a_we),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_en    (rd_en),
    .b_addr  (rd_addr),
    .b_rdata (b_rdata)
  );

  assign op_kind = op_e;

  logic    id_mode_q;
  rd_src_e src_q;
  logic    tog_q;
  logic [7:0] id_q, stat_q;

  always_ff @(posedge clk) begin
    if (rst)             id_mode_q <= 1'b0;
    else if (cmd.id_in)  id_mode_q <= 1'b1;
    else if (cmd.id_out) id_mode_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= RS_ARRAY;
      tog_q  <= 1'b0;
      id_q   <= '0;
      stat_q <= '0;
    end else if (rd_en) begin
      if (busy) begin
        src_q  <= RS_STAT;
        stat_q <= {poll7, tog_q, 6'b0};
        tog_q  <= ~tog_q;
      end else if (id_mode_q) begin
        src_q <= RS_ID;
        if (rd_addr == ADDR_W'(0))      id_q <= MFR_CODE;
        else if (rd_addr == ADDR_W'(1)) id_q <= DEV_CODE;
        else if (rd_addr == ADDR_W'(2)) id_q <= {7'b0, boot_locked};
        else                            id_q <= 8'h00;
      end else begin
        src_q <= RS_ARRAY;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      RS_ID:   rd_data = id_q;
      RS_STAT: rd_data = stat_q;
      default: rd_data = b_rdata;
    endcase
  end

  AST_ID_EXIT: assert property (@(posedge clk) disable iff (rst)
    cmd.id_out |=> !id_mode_q); // R6

  AST_STAT_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (src_q == RS_STAT) |-> (rd_data[5:0] == 6'b0)); // R8

endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;

  localparam int AW    = 12;
  localparam int PROGC = 20;
  localparam int ERAC  = 4104;
  localparam logic [AW-1:0] K1 = 12'h555;
  localparam logic [AW-1:0] K2 = 12'hAAA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic busy, boot_locked;
  logic [1:0] op_kind;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .op_kind(op_kind), .boot_locked(boot_locked)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic cmd3(input logic [7:0] c);
    wr(K1, 8'hAA); wr(K2, 8'h55); wr(K1, c);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    cmd3(8'hA0); wr(a, d);
  endtask

  task automatic cmd6(input logic [7:0] c);
    cmd3(8'h80); wr(K1, 8'hAA); wr(K2, 8'h55); wr(K1, c);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 busy after reset", busy, 0);
    chk("R1 op_kind after reset", op_kind, 0);
    chk("R5 lock clear at power-up", boot_locked, 0);
    rd(12'h123, d);
    chk("R1 erased byte", d, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] d, s1, s2;
    int n;
    prog(12'h300, 8'h5A);
    chk("R2 op_kind program", op_kind, 2'd1);
    rd(12'h300, s1);
    rd(12'h300, s2);
    chk("R8 poll bit7 program", s1[7], 1'b1);
    chk("R8 low bits zero", s1[5:0], 0);
    chk("R8 toggle bit alternates", s1[6] ^ s2[6], 1'b1);
    count_busy(n);
    chk("R2 program busy length", n, PROGC - 4);
    rd(12'h300, d);
    chk("R2 programmed value", d, 8'h5A);
    chk("R10 read latency", rd_data, 8'h5A);
    prog(12'h300, 8'h0F);
    count_busy(n);
    chk("R2 program busy cycles", n, PROGC);
    rd(12'h300, d);
    chk("R2 AND with old data", d, 8'h0A);
    prog(12'h010, 8'h33);
    count_busy(n);
    rd(12'h010, d);
    chk("R4 boot programmable before lock", d, 8'h33);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    cmd3(8'h77);
    wr(12'h301, 8'h00);
    chk("R7 no operation started", busy, 0);
    rd(12'h301, d);
    chk("R7 array unchanged", d, 8'hFF);
    wr(K1, 8'hAA); wr(K1, 8'h55); wr(K1, 8'hA0); wr(12'h302, 8'h00);
    chk("R7 wrong key address", busy, 0);
    rd(12'h302, d);
    chk("R7 array unchanged 2", d, 8'hFF);
  endtask

  task automatic t_id();
    logic [7:0] d;
    cmd3(8'h90);
    rd(12'h000, d); chk("R6 manufacturer code", d, 8'h3C);
    rd(12'h001, d); chk("R6 device code", d, 8'hA5);
    rd(12'h002, d); chk("R6 lock status unlocked", d, 8'h00);
    rd(12'h005, d); chk("R6 other id address", d, 8'h00);
    cmd3(8'hF0);
    rd(12'h300, d); chk("R6 exit restores array reads", d, 8'h0A);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    int n;
    prog(12'h500, 8'hF0);
    prog(12'h501, 8'h00);
    count_busy(n);
    @(negedge clk);
    chk("R9 no second operation", busy, 0);
    rd(12'h501, d);
    chk("R9 write during busy ignored", d, 8'hFF);
    rd(12'h500, d);
    chk("R9 first program intact", d, 8'hF0);
  endtask

  task automatic t_erase();
    logic [7:0] d, s;
    int n;
    cmd6(8'h10);
    chk("R3 op_kind erase", op_kind, 2'd2);
    rd(12'h000, s);
    chk("R8 poll bit7 erase", s[7], 1'b0);
    count_busy(n);
    chk("R3 erase busy length", n, ERAC - 2);
    rd(12'h300, d); chk("R3 main byte erased", d, 8'hFF);
    rd(12'h010, d); chk("R3 boot byte erased while unlocked", d, 8'hFF);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    int n;
    prog(12'h020, 8'h11); count_busy(n);
    prog(12'h1FF, 8'h66); count_busy(n);
    prog(12'h600, 8'h22); count_busy(n);
    cmd6(8'h40);
    chk("R4 lock set", boot_locked, 1'b1);
    chk("R4 lock is not timed", busy, 0);
    cmd3(8'h90);
    rd(12'h002, d); chk("R6 lock status locked", d, 8'h01);
    cmd3(8'hF0);
    prog(12'h020, 8'h00);
    chk("R4 boot program dropped", busy, 0);
    rd(12'h020, d); chk("R4 boot byte kept", d, 8'h11);
    prog(12'h200, 8'h77);
    chk("R4 first main address accepted", busy, 1'b1);
    count_busy(n);
    rd(12'h200, d); chk("R4 first main address programmed", d, 8'h77);
    cmd6(8'h10);
    count_busy(n);
    rd(12'h020, d); chk("R4 boot survives erase", d, 8'h11);
    rd(12'h1FF, d); chk("R4 last boot byte survives", d, 8'h66);
    rd(12'h200, d); chk("R4 first main byte erased", d, 8'hFF);
    rd(12'h600, d); chk("R4 main byte erased", d, 8'hFF);
    prog(12'h600, 8'h44); count_busy(n);
    rd(12'h600, d); chk("R4 main still programmable", d, 8'h44);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5 lock survives reset", boot_locked, 1'b1);
    cmd3(8'h90); cmd3(8'hF0); cmd6(8'h10);
    count_busy(n);
    chk("R5 lock survives commands", boot_locked, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_abort();
    t_id();
    t_busy_ignore();
    t_erase();
    t_lock();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule